// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block is the device side of a receive DMA engine. It walks a circular table of 8-byte buffer descriptors in memory and writes each incoming byte-stream frame into the buffer named by the descriptor at its current position. At the end of each frame it stores a header word at the start of that buffer, moves to the next descriptor, and pulses an interrupt.

Descriptors carry no ownership flag. The host grants descriptors to the device in only one way: it moves a byte-offset end pointer forward. The engine fills entries from its current position up to the entry just before that pointer. The ring wraps when the engine finishes a descriptor that has its end-of-table flag set. Software finds new entries by comparing the engine's position, read from a status register, with its own consumer index.

Top module: `rxring_dma`

## Requirements
- R1: A descriptor for position i sits at ring base + 8*i. Its first word holds the end-of-table flag in bit 28 and the buffer capacity in bytes in bits 12:0. Its second word holds the buffer byte address.
- R2: Frame byte j is stored in byte lane j mod 4 of the 32-bit word at buffer address + 4 + 4*(j/4). The lanes of the last data word that receive no byte are written as zero.
- R3: After the last byte of a frame, the word at the buffer address is written with the stored length in bits 15:0 and an overflow flag in bit 16. All other bits are zero.
- R4: Bytes beyond the descriptor capacity are dropped, and no memory past the capacity (rounded up to a word) is written. A frame that loses bytes this way gets the overflow flag set.
- R5: Each completed frame advances the current position by one, modulo the ring size. The interrupt output goes high for exactly one cycle.
- R6: After a frame completes in a descriptor whose end-of-table flag is set, the next position is 0.
- R7: The end pointer is a byte offset from the ring base. While the current position equals end pointer / 8, a frame start is held: frame ready stays low and no memory request is made.
- R8: A write to the end pointer that moves it away from the current position lets a held frame proceed.
- R9: Register addresses: 0 = ring base, 1 = end pointer, 2 = status. Status returns the current position times 8. After reset all three read 0, and both interrupt and memory request are low.
- R10: Writing the ring base resets the current position to 0. The descriptors after that are fetched from the new base.
- R11: A memory request without a grant is held next cycle with unchanged address and write enable.
- R12: While idle, a byte without the start marker is accepted and discarded. It changes neither the position nor the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fr_valid | input | 1 | Frame byte valid |
| fr_sof | input | 1 | First byte of frame |
| fr_eof | input | 1 | Last byte of frame |
| fr_data | input | 8 | Frame byte |
| fr_ready | output | 1 | Byte accepted when high with fr_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Grant, completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| irq | output | 1 | One-cycle frame-complete pulse |

## Verification
A vector table sends frames shorter than one word, exactly one word, odd lengths, a length equal to the capacity, and lengths past the capacity. These separate correct lane packing and zero fill from off-by-one truncation and overflow flag errors. The table sweeps across a four-entry ring whose last descriptor has the end-of-table flag, so the wrap to position 0 is exercised. An irregular grant pattern stretches every access. Directed cases then hold a frame at the end pointer and release it, feed a stray byte with no start marker, and move the ring base to show that positions and descriptor fetches restart there.

// File: rtl/rxring_dma.sv
module rxring_dma #(
  parameter int AW           = 32,
  parameter int RING_ENTRIES = 512,
  parameter int LEN_W        = 13,
  parameter int EOT_BIT      = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fr_valid,
  input  logic          fr_sof,
  input  logic          fr_eof,
  input  logic [7:0]    fr_data,
  output logic          fr_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int IW = $clog2(RING_ENTRIES);
  localparam int OW = IW + 3;

  typedef enum logic [2:0] {S_IDLE, S_D0, S_D1, S_RX, S_WR, S_HDR} st_t;
  st_t state;

  logic [AW-1:0]    base_q, buf_q, waddr_q;
  logic [OW-1:0]    endp_q;
  logic [IW-1:0]    cur_q;
  logic [LEN_W-1:0] blen_q, cnt_q;
  logic             eot_q, ovf_q, last_q, dirty_q;
  logic [31:0]      wbuf_q;

  wire [IW-1:0] end_idx = endp_q[OW-1:3];
  wire          open_w  = cur_q != end_idx;
  wire [AW-1:0] desc_a  = base_q + (AW'(cur_q) << 3);
  wire          done    = mem_req && mem_gnt;
  wire          take    = fr_valid && fr_ready && state == S_RX;
  wire          store   = cnt_q < blen_q;
  wire          go_wr   = (store && cnt_q[1:0] == 2'd3) || (fr_eof && (dirty_q || store));

  assign fr_ready  = (state == S_IDLE && fr_valid && !fr_sof) || state == S_RX;
  assign mem_req   = state == S_D0 || state == S_D1 || state == S_WR || state == S_HDR;
  assign mem_we    = state == S_WR || state == S_HDR;
  assign mem_wdata = (state == S_HDR) ? {15'd0, ovf_q, 16'(cnt_q)} : wbuf_q;

  always_comb begin
    case (state)
      S_D0:    mem_addr = desc_a;
      S_D1:    mem_addr = desc_a + AW'(4);
      S_WR:    mem_addr = waddr_q;
      S_HDR:   mem_addr = buf_q;
      default: mem_addr = '0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(base_q);
      2'd1:    reg_rdata = 32'(endp_q);
      2'd2:    reg_rdata = 32'({cur_q, 3'b000});
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; base_q <= '0; endp_q <= '0; cur_q <= '0; irq <= 1'b0;
      buf_q <= '0; waddr_q <= '0; blen_q <= '0; cnt_q <= '0; eot_q <= 1'b0;
      ovf_q <= 1'b0; last_q <= 1'b0; dirty_q <= 1'b0; wbuf_q <= '0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: if (fr_valid && fr_sof && open_w) state <= S_D0;
        S_D0: if (done) begin
          eot_q  <= mem_rdata[EOT_BIT];
          blen_q <= mem_rdata[LEN_W-1:0];
          state  <= S_D1;
        end
        S_D1: if (done) begin
          buf_q <= mem_rdata[AW-1:0];
          cnt_q <= '0; ovf_q <= 1'b0; dirty_q <= 1'b0; wbuf_q <= '0; last_q <= 1'b0;
          state <= S_RX;
        end
        S_RX: if (take) begin
          if (store) begin
            wbuf_q[8*cnt_q[1:0] +: 8] <= fr_data;
            waddr_q <= buf_q + AW'(4) + AW'({cnt_q[LEN_W-1:2], 2'b00});
            cnt_q   <= cnt_q + 1'b1;
            dirty_q <= 1'b1;
          end else begin
            ovf_q <= 1'b1;
          end
          last_q <= fr_eof;
          state  <= go_wr ? S_WR : (fr_eof ? S_HDR : S_RX);
        end
        S_WR: if (done) begin
          wbuf_q  <= '0;
          dirty_q <= 1'b0;
          state   <= last_q ? S_HDR : S_RX;
        end
        S_HDR: if (done) begin
          cur_q <= eot_q ? '0 : cur_q + 1'b1;
          irq   <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (reg_we && reg_addr == 2'd1) endp_q <= reg_wdata[OW-1:0];
      if (reg_we && reg_addr == 2'd0) begin
        base_q <= reg_wdata[AW-1:0];
        cur_q  <= '0;
      end
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_stall_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && fr_valid && fr_sof && cur_q == end_idx |-> !fr_ready ##1 !mem_req);

  assert_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WR |-> (mem_addr - buf_q - AW'(4)) < AW'(blen_q));

  assert_hdr_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HDR |-> mem_wdata[LEN_W-1:0] <= blen_q);

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !$past(reg_we && reg_addr == 2'd0) |->
      cur_q == ($past(eot_q) ? '0 : IW'($past(cur_q) + 1'b1)));
endmodule

// File: tb/sim_rxring_dma.sv
module sim_rxring_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0; logic [1:0] reg_addr = '0; logic [31:0] reg_wdata = '0, reg_rdata;
  logic fr_valid = 1'b0, fr_sof = 1'b0, fr_eof = 1'b0, fr_ready; logic [7:0] fr_data = '0;
  logic mem_req, mem_we, mem_gnt = 1'b0, irq; logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [2048];
  int checks = 0, fails = 0, gcnt = 0, hold_err = 0;
  logic pend = 1'b0, pwe = 1'b0; logic [31:0] paddr = '0;

  always #4 clk = ~clk;

  rxring_dma u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fr_valid(fr_valid), .fr_sof(fr_sof),
    .fr_eof(fr_eof), .fr_data(fr_data), .fr_ready(fr_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .irq(irq));

  assign mem_rdata = mem[mem_addr[12:2]];

  always @(negedge clk) begin
    gcnt++;
    mem_gnt <= (gcnt % 3) != 1;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (pend && !(mem_req && mem_addr == paddr && mem_we == pwe)) hold_err++;
      if (mem_req && mem_we && mem_gnt) mem[mem_addr[12:2]] = mem_wdata;
      pend  = mem_req && !mem_gnt;
      paddr = mem_addr;
      pwe   = mem_we;
    end
  end

  localparam int NV = 6;
  localparam int FLEN  [NV] = '{5, 8, 1, 20, 4, 7};
  localparam int BLEN  [NV] = '{64, 64, 64, 10, 4, 6};
  localparam int SLOT  [NV] = '{0, 1, 2, 3, 0, 1};
  localparam int XLEN  [NV] = '{5, 8, 1, 10, 4, 6};
  localparam int XOVF  [NV] = '{0, 0, 0, 1, 0, 1};
  localparam int XNEXT [NV] = '{1, 2, 3, 0, 1, 2};

  function automatic logic [7:0] pat(input int f, input int j);
    return 8'(f * 37 + j + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(input int f, input int n, input bit with_sof);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      fr_valid = 1'b1; fr_sof = with_sof && j == 0; fr_eof = j == n - 1; fr_data = pat(f, j);
      #1;
      while (!fr_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk); fr_valid = 1'b0; fr_sof = 1'b0; fr_eof = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 500 && !seen; k++) begin @(negedge clk); if (irq) seen = 1'b1; end
  endtask

  task automatic set_desc(input logic [31:0] dbase, input int slot, input int blen, input bit eot, input logic [31:0] ba);
    mem[(dbase + 32'(slot * 8)) >> 2]     = (eot ? 32'h1000_0000 : 32'h0) | 32'(blen);
    mem[(dbase + 32'(slot * 8) + 4) >> 2] = ba;
    for (int w = 0; w < 64; w++) mem[(ba >> 2) + 32'(w)] = 32'hDEAD_BEEF;
  endtask

  task automatic check_buf(input int f, input logic [31:0] ba, input int xlen, input int xovf, input string tag);
    logic [31:0] expw; bit ok; int nw;
    expw = {15'd0, 1'(xovf), 16'(xlen)};
    chk(mem[ba >> 2] == expw, {tag, " R3 header"}, mem[ba >> 2], expw);
    nw = (xlen + 3) / 4; ok = 1'b1;
    for (int w = 0; w < nw; w++) begin
      expw = '0;
      for (int b = 0; b < 4; b++) if (w * 4 + b < xlen) expw[8*b +: 8] = pat(f, w * 4 + b);
      if (mem[(ba >> 2) + 32'(1 + w)] != expw) ok = 1'b0;
    end
    chk(ok, {tag, " R1 R2 data words"}, mem[(ba >> 2) + 1], {pat(f, 3), pat(f, 2), pat(f, 1), pat(f, 0)});
    if (xovf != 0)
      chk(mem[(ba >> 2) + 32'(1 + nw)] == 32'hDEAD_BEEF, {tag, " R4 no write past capacity"},
          mem[(ba >> 2) + 32'(1 + nw)], 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d; bit seen;
    for (int w = 0; w < 2048; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    rd_reg(2'd2, d); chk(d == 0, "R9 status after reset", d, 0);
    rd_reg(2'd1, d); chk(d == 0, "R9 end pointer after reset", d, 0);
    chk(!irq && !mem_req && !fr_ready, "R9 outputs idle after reset", {irq, mem_req, fr_ready}, 0);
    wr_reg(2'd0, 32'h0);

    // Table walk: R1..R6
    for (int v = 0; v < NV; v++) begin
      logic [31:0] ba;
      ba = 32'h400 + 32'(SLOT[v] * 256);
      set_desc(32'h0, SLOT[v], BLEN[v], SLOT[v] == 3, ba);
      wr_reg(2'd1, 32'(XNEXT[v] * 8));
      send(v, FLEN[v], 1'b1);
      wait_irq(seen);
      chk(seen, "R5 interrupt after frame", 32'(seen), 1);
      @(negedge clk);
      chk(!irq, "R5 interrupt one cycle", 32'(irq), 0);
      check_buf(v, ba, XLEN[v], XOVF[v], $sformatf("vec%0d", v));
      rd_reg(2'd2, d);
      chk(d == 32'(XNEXT[v] * 8), SLOT[v] == 3 ? "R6 wrap to zero" : "R5 position advance", d, 32'(XNEXT[v] * 8));
    end

    // R7 hold at end pointer, R8 release
    set_desc(32'h0, 2, 64, 1'b0, 32'h600);
    wr_reg(2'd1, 32'd16);
    @(negedge clk); fr_valid = 1'b1; fr_sof = 1'b1; fr_eof = 1'b0; fr_data = pat(9, 0);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (fr_ready || irq || mem_req) seen = 1'b1; end
    chk(!seen, "R7 frame held at end pointer", 32'(seen), 0);
    rd_reg(2'd2, d); chk(d == 32'd16, "R7 position unchanged while held", d, 16);
    wr_reg(2'd1, 32'd24);
    send(9, 3, 1'b1);
    wait_irq(seen);
    chk(seen, "R8 resumes after end pointer write", 32'(seen), 1);
    check_buf(9, 32'h600, 3, 0, "resume R8");
    rd_reg(2'd2, d); chk(d == 32'd24, "R8 position after resumed frame", d, 24);

    // R12 stray byte in idle
    wr_reg(2'd1, 32'd0);
    send(10, 1, 1'b0);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (irq) seen = 1'b1; end
    chk(!seen, "R12 stray byte no interrupt", 32'(seen), 0);
    rd_reg(2'd2, d); chk(d == 32'd24, "R12 stray byte position unchanged", d, 24);

    // R10 base write
    for (int w = 0; w < 64; w++) mem[(32'h400 >> 2) + 32'(w)] = 32'hDEAD_BEEF;
    wr_reg(2'd0, 32'h200);
    rd_reg(2'd2, d); chk(d == 0, "R10 position reset by base write", d, 0);
    set_desc(32'h200, 0, 64, 1'b0, 32'h800);
    wr_reg(2'd1, 32'd8);
    send(11, 6, 1'b1);
    wait_irq(seen);
    chk(seen, "R10 frame at new base", 32'(seen), 1);
    check_buf(11, 32'h800, 6, 0, "newbase R10");
    chk(mem[32'h400 >> 2] == 32'hDEAD_BEEF, "R10 old ring buffer untouched", mem[32'h400 >> 2], 32'hDEAD_BEEF);
    rd_reg(2'd2, d); chk(d == 32'd8, "R10 position after frame", d, 8);

    chk(hold_err == 0, "R11 request held until grant", 32'(hold_err), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule